// File: doc/BRIEF.md
# Synchronous Up/Down Decade Counter

This block is a four-bit synchronous counter that steps up or down on each enabled clock edge. A parameter selects decimal operation, where the count runs through 0 to 9, or binary operation, where it runs through 0 to 15. A direction input picks the way it counts, an active-low enable gates counting, and an active-low load input presets the count from a four-bit data word. All state changes happen on the rising clock edge.

Two outputs support cascading stages. A terminal flag is high while the count sits at the last value for the present direction: the top value when counting up, zero when counting down. An active-low ripple output pulses low for one clock cycle after an edge at which the counter wrapped, and a following stage can use that pulse as its enable.

Top module: `updn_decade_ctr`

## Requirements
- R1: While `rst_n` is low at a rising edge, the count becomes 0 and `rco_n_o` becomes 1 after that edge.
- R2: With `load_n` high, `en_n` low and `down` low, each edge adds one to the count, and the top value wraps to 0. The top value is 9 in decimal mode and 15 in binary mode.
- R3: With `load_n` high, `en_n` low and `down` high, each edge subtracts one from the count, and 0 wraps to the top value.
- R4: With `load_n` high and `en_n` high, the count holds at every edge, whatever the value of `down`.
- R5: With `load_n` low, the next edge copies `data_i` into the count, whatever the values of `en_n` and `down`. Load takes priority over counting.
- R6: `maxmin_o` is combinational. It is 1 exactly when `down` is 0 and the count equals the top value, or when `down` is 1 and the count is 0.
- R7: `rco_n_o` is 0 for the one cycle after an edge at which `maxmin_o` was 1, `en_n` was 0 and `load_n` was 1. In every other cycle after reset it is 1.
- R8: In decimal mode, a loaded count of 10 to 15 holds while the counter is disabled. The next enabled edge moves it to 0 when counting up and to 9 when counting down.
- R9: In binary mode (parameter `DECADE` = 0), the counter uses all 16 states and wraps between 15 and 0 in both directions.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| load_n | input | 1 | Parallel load, active low, takes priority over counting |
| en_n | input | 1 | Count enable, active low |
| down | input | 1 | Direction: 0 counts up, 1 counts down |
| data_i | input | 4 | Value loaded when `load_n` is low |
| count_o | output | 4 | Present count |
| maxmin_o | output | 1 | Terminal count for the present direction |
| rco_n_o | output | 1 | One-cycle active-low ripple pulse after a wrap |

## Verification
The assertions check on every cycle the step-by-step rules of the counter: load copying, holding, increment, decrement, both wraps, and recovery from an out-of-range value. They also check that the ripple pulse follows each enabled terminal edge and that the terminal flag is raised only at 0 or at the top value. Some behaviours show only in the bench's scenarios: the flag following a change of `down` in the same cycle, the ripple output staying high when a load overrides a terminal count, and whole count sequences in decimal and binary mode side by side. The bench's cycle-level model covers these, including the exact values that follow a load of 12 or 14.

// File: rtl/ctr_pkg.sv
// Package: shared types and constants for the up/down counter.
// Assumes: counts are unsigned; direction is a single bit (0 = up).
package ctr_pkg;

    // Count direction as seen on the direction pin.
    typedef enum logic {
        DIR_UP   = 1'b0,
        DIR_DOWN = 1'b1
    } dir_e;

    // Last valid value of a decimal digit.
    localparam int DEC_LAST = 9;

endpackage : ctr_pkg

// File: rtl/ctr_step.sv
// Module: ctr_step
// Computes the next count value for an enabled edge in either direction.
// Assumes: TOP is the last value of the sequence. In decimal mode, values
// above TOP are out of range and return to the sequence in one step.
module ctr_step #(
    parameter int              WIDTH  = 4,
    parameter bit              DECADE = 1'b1,
    parameter logic [WIDTH-1:0] TOP   = WIDTH'(ctr_pkg::DEC_LAST)
) (
    input  logic [WIDTH-1:0] cnt,
    input  ctr_pkg::dir_e    dir,
    output logic [WIDTH-1:0] nxt
);
    import ctr_pkg::*;

    generate
        if (DECADE) begin : g_dec
            // Decimal step with wrap and out-of-range repair.
            always_comb begin
                if (dir == DIR_UP) begin
                    nxt = (cnt >= TOP) ? '0 : cnt + WIDTH'(1);
                end else begin
                    nxt = ((cnt == '0) || (cnt > TOP)) ? TOP : cnt - WIDTH'(1);
                end
            end
        end else begin : g_bin
            // Binary step wraps by natural overflow.
            always_comb begin
                nxt = (dir == DIR_UP) ? cnt + WIDTH'(1) : cnt - WIDTH'(1);
            end
        end
    endgenerate

endmodule : ctr_step

// File: rtl/ctr_terminal.sv
// Module: ctr_terminal
// Flags the terminal count for the present direction: TOP going up, zero
// going down. Purely combinational.
// Assumes: TOP matches the one used by ctr_step.
module ctr_terminal #(
    parameter int               WIDTH = 4,
    parameter logic [WIDTH-1:0] TOP   = WIDTH'(ctr_pkg::DEC_LAST)
) (
    input  logic [WIDTH-1:0] cnt,
    input  ctr_pkg::dir_e    dir,
    output logic             at_end
);
    import ctr_pkg::*;

    // Compare the count against the end value for the chosen direction.
    always_comb begin
        if (dir == DIR_UP) begin
            at_end = (cnt == TOP);
        end else begin
            at_end = (cnt == '0);
        end
    end

endmodule : ctr_terminal

// File: rtl/ctr_ripple.sv
// Module: ctr_ripple
// Produces a one-cycle active-low pulse after an edge at which the counter
// wrapped (terminal count, enabled, not loading).
// Assumes: synchronous active-low reset; the pulse idles high.
module ctr_ripple (
    input  logic clk,
    input  logic rst_n,
    input  logic at_end,
    input  logic en_n,
    input  logic load_n,
    output logic rco_n
);
    logic wrap_now;

    // A wrap happens only when counting is active and no load overrides it.
    always_comb begin
        wrap_now = at_end & ~en_n & load_n;
    end

    // Register the pulse so that it lasts exactly one clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rco_n <= 1'b1;
        end else begin
            rco_n <= ~wrap_now;
        end
    end

endmodule : ctr_ripple

// File: rtl/updn_decade_ctr.sv
// Module: updn_decade_ctr (top)
// Synchronous up/down counter, decimal (DECADE=1) or binary (DECADE=0).
// Load (active low) beats count enable (active low); otherwise the count
// holds. Outputs a terminal flag and a registered ripple pulse for cascades.
// Assumes: one clock domain, synchronous active-low reset.
module updn_decade_ctr #(
    parameter int WIDTH  = 4,
    parameter bit DECADE = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_n,
    input  logic             en_n,
    input  logic             down,
    input  logic [WIDTH-1:0] data_i,
    output logic [WIDTH-1:0] count_o,
    output logic             maxmin_o,
    output logic             rco_n_o
);
    import ctr_pkg::*;

    localparam logic [WIDTH-1:0] TOP = DECADE ? WIDTH'(DEC_LAST) : {WIDTH{1'b1}};

    dir_e             dir;
    logic [WIDTH-1:0] cnt_q;
    logic [WIDTH-1:0] cnt_step;
    logic             at_end;

    // Map the direction pin onto the package type.
    always_comb begin
        dir = dir_e'(down);
    end

    ctr_step #(
        .WIDTH (WIDTH),
        .DECADE(DECADE),
        .TOP   (TOP)
    ) u_step (
        .cnt(cnt_q),
        .dir(dir),
        .nxt(cnt_step)
    );

    ctr_terminal #(
        .WIDTH(WIDTH),
        .TOP  (TOP)
    ) u_term (
        .cnt   (cnt_q),
        .dir   (dir),
        .at_end(at_end)
    );

    ctr_ripple u_rip (
        .clk   (clk),
        .rst_n (rst_n),
        .at_end(at_end),
        .en_n  (en_n),
        .load_n(load_n),
        .rco_n (rco_n_o)
    );

    // Count register: reset, then load, then enabled step, else hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!load_n) begin
            cnt_q <= data_i;
        end else if (!en_n) begin
            cnt_q <= cnt_step;
        end
    end

    assign count_o  = cnt_q;
    assign maxmin_o = at_end;

endmodule : updn_decade_ctr

// File: rtl/updn_decade_ctr_chk.sv
// Module: updn_decade_ctr_chk
// Property checker bound to every updn_decade_ctr instance. Sees ports only.
module updn_decade_ctr_chk #(
    parameter int WIDTH  = 4,
    parameter bit DECADE = 1'b1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             load_n,
    input logic             en_n,
    input logic             down,
    input logic [WIDTH-1:0] data_i,
    input logic [WIDTH-1:0] count_o,
    input logic             maxmin_o,
    input logic             rco_n_o
);
    localparam logic [WIDTH-1:0] TOP = DECADE ? WIDTH'(9) : {WIDTH{1'b1}};

    p_reset_r1: assert property (@(posedge clk)
        !rst_n |=> (count_o == '0) && rco_n_o);

    p_up_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (load_n && !en_n && !down && count_o < TOP) |=> count_o == $past(count_o) + WIDTH'(1));

    p_up_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (load_n && !en_n && !down && count_o == TOP) |=> count_o == '0);

    p_dn_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (load_n && !en_n && down && count_o != '0 && count_o <= TOP) |=> count_o == $past(count_o) - WIDTH'(1));

    p_dn_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (load_n && !en_n && down && count_o == '0) |=> count_o == TOP);

    p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (load_n && en_n) |=> $stable(count_o));

    p_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !load_n |=> count_o == $past(data_i));

    p_flag_pos_r6: assert property (@(posedge clk) disable iff (!rst_n)
        maxmin_o |-> (count_o == TOP || count_o == '0));

    p_rco_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (maxmin_o && !en_n && load_n) |=> !rco_n_o);

    p_rco_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(maxmin_o && !en_n && load_n) |=> rco_n_o);

    p_repair_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (load_n && !en_n && count_o > TOP) |=> count_o == (down ? TOP : '0));

endmodule : updn_decade_ctr_chk

bind updn_decade_ctr updn_decade_ctr_chk #(
    .WIDTH (WIDTH),
    .DECADE(DECADE)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_n  (load_n),
    .en_n    (en_n),
    .down    (down),
    .data_i  (data_i),
    .count_o (count_o),
    .maxmin_o(maxmin_o),
    .rco_n_o (rco_n_o)
);

// File: tb/updn_decade_ctr_test.sv
`timescale 1ns/100ps
module updn_decade_ctr_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       load_n = 1'b1;
    logic       en_n = 1'b1;
    logic       down = 1'b0;
    logic [3:0] data_i = '0;

    logic [3:0] cnt_d, cnt_b;
    logic       mm_d, mm_b, rco_d, rco_b;

    int    n_checks = 0;
    int    n_errors = 0;
    bit    checking = 1'b0;
    string cur_req = "R1";

    // Reference state: decimal and binary models.
    int m_cnt_d = 0, m_cnt_b = 0;
    bit m_rco_d = 1'b1, m_rco_b = 1'b1;

    always #2.5 clk = ~clk;

    updn_decade_ctr #(.WIDTH(4), .DECADE(1'b1)) uut (
        .clk(clk), .rst_n(rst_n), .load_n(load_n), .en_n(en_n), .down(down),
        .data_i(data_i), .count_o(cnt_d), .maxmin_o(mm_d), .rco_n_o(rco_d));

    updn_decade_ctr #(.WIDTH(4), .DECADE(1'b0)) uut_bin (
        .clk(clk), .rst_n(rst_n), .load_n(load_n), .en_n(en_n), .down(down),
        .data_i(data_i), .count_o(cnt_b), .maxmin_o(mm_b), .rco_n_o(rco_b));

    function automatic int next_val(int c, bit dn, int top);
        if (!dn) return (c >= top) ? 0 : c + 1;
        return (c == 0 || c > top) ? top : c - 1;
    endfunction

    function automatic bit term(int c, bit dn, int top);
        return dn ? (c == 0) : (c == top);
    endfunction

    // Model update at the clock edge; inputs change 1 ns after the edge.
    always @(posedge clk) begin
        bit wd, wb;
        if (!rst_n) begin
            m_cnt_d = 0; m_cnt_b = 0; m_rco_d = 1'b1; m_rco_b = 1'b1;
        end else begin
            wd = term(m_cnt_d, down, 9)  && !en_n && load_n;
            wb = term(m_cnt_b, down, 15) && !en_n && load_n;
            m_rco_d = !wd;
            m_rco_b = !wb;
            if (!load_n) begin
                m_cnt_d = data_i; m_cnt_b = data_i;
            end else if (!en_n) begin
                m_cnt_d = next_val(m_cnt_d, down, 9);
                m_cnt_b = next_val(m_cnt_b, down, 15);
            end
        end
    end

    task automatic check(string req, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // Compare every cycle, mid-period.
    always @(negedge clk) begin
        if (checking) begin
            check(cur_req, cnt_d, m_cnt_d);
            check({"R9 ", cur_req}, cnt_b, m_cnt_b);
            check("R6", mm_d, term(m_cnt_d, down, 9));
            check("R6 R9", mm_b, term(m_cnt_b, down, 15));
            check("R7", rco_d, m_rco_d);
            check("R7 R9", rco_b, m_rco_b);
        end
    end

    task automatic drive(bit ld, bit en, bit dn, logic [3:0] d, int cycles, string req);
        @(posedge clk);
        #1;
        load_n = ld; en_n = en; down = dn; data_i = d; cur_req = req;
        repeat (cycles - 1) @(posedge clk);
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    endtask

    initial begin
        #200000;
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (2) @(posedge clk);
        checking = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check("R1", cnt_d, 0);
        check("R1", rco_d, 1);
        #1 rst_n = 1'b1;
        // R2: count up through several wraps.
        drive(1, 0, 0, 4'd0, 25, "R2");
        // R3: count down through several wraps.
        drive(1, 0, 1, 4'd0, 25, "R3");
        // R4: disabled, direction toggled, count must hold.
        drive(1, 1, 0, 4'd0, 3, "R4");
        drive(1, 1, 1, 4'd0, 3, "R4");
        // R5: load with enable active, then with enable inactive.
        drive(0, 0, 0, 4'd7, 1, "R5");
        drive(1, 0, 0, 4'd0, 2, "R5");
        drive(0, 1, 1, 4'd3, 1, "R5");
        drive(1, 1, 1, 4'd0, 2, "R5");
        // R8: out-of-range 12 holds, then steps up to 0.
        drive(0, 1, 0, 4'd12, 1, "R8");
        drive(1, 1, 0, 4'd0, 2, "R8");
        @(negedge clk);
        check("R8", cnt_d, 12);
        drive(1, 0, 0, 4'd0, 1, "R8");
        drive(1, 1, 0, 4'd0, 1, "R8");
        @(negedge clk);
        check("R8", cnt_d, 0);
        check("R9", cnt_b, 13);
        // R8: out-of-range 14 steps down to 9.
        drive(0, 1, 1, 4'd14, 1, "R8");
        drive(1, 0, 1, 4'd0, 1, "R8");
        drive(1, 1, 1, 4'd0, 1, "R8");
        @(negedge clk);
        check("R8", cnt_d, 9);
        check("R9", cnt_b, 13);
        // R6/R7: load 9 counting up, terminal with a load override, then wrap.
        drive(0, 1, 0, 4'd9, 1, "R6");
        drive(1, 1, 0, 4'd0, 1, "R6");
        @(negedge clk);
        check("R6", mm_d, 1);
        drive(0, 0, 0, 4'd5, 1, "R7");
        drive(1, 1, 0, 4'd0, 1, "R7");
        @(negedge clk);
        check("R7", rco_d, 1);
        drive(0, 1, 0, 4'd9, 1, "R7");
        drive(1, 0, 0, 4'd0, 1, "R7");
        drive(1, 1, 0, 4'd0, 1, "R7");
        @(negedge clk);
        check("R7", rco_d, 0);
        check("R2", cnt_d, 0);
        // R6: direction change flips the flag in the same cycle.
        #1 down = 1'b1;
        @(negedge clk);
        check("R6", mm_d, 1);
        // R9: binary down wrap from 0 to 15.
        drive(0, 1, 1, 4'd0, 1, "R9");
        drive(1, 0, 1, 4'd0, 1, "R9");
        drive(1, 1, 1, 4'd0, 1, "R9");
        @(negedge clk);
        check("R9", cnt_b, 15);
        check("R9", rco_b, 0);
        drive(1, 0, 0, 4'd0, 20, "R2");
        @(negedge clk);
        finish_run();
    end

endmodule : updn_decade_ctr_test